// File: doc/BRIEF.md
# Dual-Frequency Quadrature NCO

This block is a direct digital synthesis core. It holds two phase tuning words and adds one of them to a 32-bit phase accumulator on each clock. A select input can switch between the two words on any cycle, which gives binary frequency-shift keying with no extra logic. A 12-bit phase offset is added to the top of the accumulator. The result addresses a sine table and a cosine table that are built from one quarter-wave table.

The two table outputs are weighted by a signed in-phase multiplier and a signed quadrature multiplier. The sum is rounded and saturated into a 10-bit signed sample for an external converter. With these weights the block can produce amplitude-modulated, QAM or single-sideband carriers. Registers are written through a one-cycle load port. A sleep pin, or a sleep bit written through the load port, freezes the accumulator and forces the sample to zero. A synchronous reset clears all the state.

Top module: `dds_dual_nco`

## Requirements
- R1: On each awake cycle the accumulator adds the selected tuning word, modulo 2^32.
- R2: The select input is registered. A value applied before edge n picks the tuning word that is added at edge n+1 (0 selects tuning word A, 1 selects tuning word B).
- R3: The table phase is (accumulator bits [31:20] + phase offset) modulo 4096. The table index is bits [11:2] of that sum.
- R4: The sine value for index p (0..1023) is round(511·sin(2π(p+0.5)/1024)). The cosine value is the sine value at (p+256) mod 1024.
- R5: The sample is floor((I·cos + Q·sin + 256)/512). I is bits [25:16] and Q is bits [9:0] of the IQ word, both two's complement.
- R6: A result above 511 is clipped to 511, and a result below -512 is clipped to -512.
- R7: While sleep_i is high, the accumulator and table stage hold their values, and the sample is 0 from the next edge on.
- R8: Bit 0 of the control word acts like sleep_i while it is 1.
- R9: A high rst_i clears the control word, both tuning words, the phase offset, the IQ word, the accumulator, the select register and the pipeline, so the sample reads 0.
- R10: When ld_en_i is high, ld_data_i is written at the clock edge to the destination chosen by ld_dst_i. The codes are 0 for control, 1 for tuning word A, 2 for tuning word B, 3 for the phase offset (bits [11:0]) and 4 for the IQ word. Codes 5 to 7 change nothing.
- R11: The table stage registers the lookup of the accumulator value. The sample register then registers the weighted sum of that lookup. A change to the accumulator or the offset therefore reaches the sample two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fsel_i | input | 1 | Tuning word select |
| sleep_i | input | 1 | Sleep request, active high |
| ld_en_i | input | 1 | Load strobe |
| ld_dst_i | input | 3 | Load destination code |
| ld_data_i | input | 32 | Load data |
| sample_o | output | 10 | Signed output sample |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 12-bit offset, a 10-bit table index and 10-bit samples. Tuning words such as 0x0040_0000 step the table one index per clock, so a sweep over many table entries takes only a few dozen cycles. Words of 0x2000_0000 and above reach every quadrant, the octant points where saturation occurs, and an accumulator wrap within a few cycles. The bench's reference model computes the table with real-valued sine, independently of the design.

// File: rtl/dds_nco_pkg.sv
package dds_nco_pkg;

    typedef enum logic [2:0] {
        DST_CTRL   = 3'd0,
        DST_TUNE_A = 3'd1,
        DST_TUNE_B = 3'd2,
        DST_POFS   = 3'd3,
        DST_IQ     = 3'd4
    } load_dst_e;

    // pi/2 in Q30 fixed point
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // Quarter-wave entry k of qsize: amp * sin((k + 0.5) * (pi/2) / qsize), rounded
    function automatic int quarter_sine(int k, int qsize, int amp);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = (longint'(2 * k + 1) * HALF_PI_Q30) / longint'(2 * qsize);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int n = 1; n <= 6; n++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
            sum  = sum + term;
        end
        return int'((sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/dds_nco_regs.sv
module dds_nco_regs
    import dds_nco_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int POFS_W = 12,
    parameter int DW     = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 ld_en_i,
    input  load_dst_e            ld_dst_i,
    input  logic [ACC_W-1:0]     ld_data_i,
    output logic                 ctrl_sleep_o,
    output logic [ACC_W-1:0]     tune_a_o,
    output logic [ACC_W-1:0]     tune_b_o,
    output logic [POFS_W-1:0]    pofs_o,
    output logic signed [DW-1:0] iq_i_o,
    output logic signed [DW-1:0] iq_q_o
);
    localparam int I_LSB = ACC_W / 2;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_sleep_o <= 1'b0;
            tune_a_o     <= '0;
            tune_b_o     <= '0;
            pofs_o       <= '0;
            iq_i_o       <= '0;
            iq_q_o       <= '0;
        end else if (ld_en_i) begin
            case (ld_dst_i)
                DST_CTRL:   ctrl_sleep_o <= ld_data_i[0];
                DST_TUNE_A: tune_a_o     <= ld_data_i;
                DST_TUNE_B: tune_b_o     <= ld_data_i;
                DST_POFS:   pofs_o       <= ld_data_i[POFS_W-1:0];
                DST_IQ: begin
                    iq_i_o <= $signed(ld_data_i[I_LSB +: DW]);
                    iq_q_o <= $signed(ld_data_i[0 +: DW]);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dds_nco_phase.sv
module dds_nco_phase #(
    parameter int ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             awake_i,
    input  logic             fsel_i,
    input  logic [ACC_W-1:0] tune_a_i,
    input  logic [ACC_W-1:0] tune_b_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             fsel_q_o
);
    logic [ACC_W-1:0] step_w;

    assign step_w = fsel_q_o ? tune_b_i : tune_a_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_o    <= '0;
            fsel_q_o <= 1'b0;
        end else begin
            fsel_q_o <= fsel_i;
            if (awake_i) begin
                acc_o <= acc_o + step_w;
            end
        end
    end
endmodule

// File: rtl/dds_nco_trig.sv
module dds_nco_trig
    import dds_nco_pkg::*;
#(
    parameter int POFS_W = 12,
    parameter int LUT_AW = 10,
    parameter int DW     = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 awake_i,
    input  logic [POFS_W-1:0]    phase_top_i,
    input  logic [POFS_W-1:0]    pofs_i,
    output logic signed [DW-1:0] sin_o,
    output logic signed [DW-1:0] cos_o
);
    localparam int QAW   = LUT_AW - 2;
    localparam int QN    = 1 << QAW;
    localparam int MAG_W = DW - 1;
    localparam int AMP   = (1 << (DW - 1)) - 1;

    logic [MAG_W-1:0]     qtab [QN];
    logic [POFS_W-1:0]    ph_sum;
    logic [LUT_AW-1:0]    idx;
    logic                 unused_frac;
    logic signed [DW-1:0] val [2];

    for (genvar k = 0; k < QN; k++) begin : g_tab
        localparam int V = quarter_sine(k, QN, AMP);
        assign qtab[k] = MAG_W'(V);
    end

    assign ph_sum      = phase_top_i + pofs_i;
    assign idx         = ph_sum[POFS_W-1 -: LUT_AW];
    assign unused_frac = ^ph_sum[POFS_W-LUT_AW-1:0];

    // channel 0 reads sine, channel 1 reads cosine (a quarter turn ahead)
    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic [LUT_AW-1:0] cidx;
        logic [1:0]        quad;
        logic [QAW-1:0]    fold;
        logic [MAG_W-1:0]  mag;
        assign cidx   = idx + LUT_AW'(c * QN);
        assign quad   = cidx[LUT_AW-1 -: 2];
        assign fold   = quad[0] ? ~cidx[QAW-1:0] : cidx[QAW-1:0];
        assign mag    = qtab[fold];
        assign val[c] = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sin_o <= '0;
            cos_o <= '0;
        end else if (awake_i) begin
            sin_o <= val[0];
            cos_o <= val[1];
        end
    end
endmodule

// File: rtl/dds_nco_mix.sv
module dds_nco_mix #(
    parameter int DW = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 awake_i,
    input  logic signed [DW-1:0] sin_i,
    input  logic signed [DW-1:0] cos_i,
    input  logic signed [DW-1:0] iq_i_i,
    input  logic signed [DW-1:0] iq_q_i,
    output logic signed [DW-1:0] sample_o
);
    localparam int PW = 2 * DW;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] SAT_HI = SW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;
    localparam logic signed [SW-1:0] HALF   = SW'(1 <<< (DW - 2));

    logic signed [PW-1:0] prod_i;
    logic signed [PW-1:0] prod_q;
    logic signed [SW-1:0] mac;
    logic signed [SW-1:0] scaled;
    logic signed [DW-1:0] clipped;

    assign prod_i = iq_i_i * cos_i;
    assign prod_q = iq_q_i * sin_i;
    assign mac    = SW'(prod_i) + SW'(prod_q);
    assign scaled = (mac + HALF) >>> (DW - 1);

    always_comb begin
        if (scaled > SAT_HI) begin
            clipped = SAT_HI[DW-1:0];
        end else if (scaled < SAT_LO) begin
            clipped = SAT_LO[DW-1:0];
        end else begin
            clipped = scaled[DW-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !awake_i) begin
            sample_o <= '0;
        end else begin
            sample_o <= clipped;
        end
    end
endmodule

// File: rtl/dds_dual_nco.sv
module dds_dual_nco
    import dds_nco_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int POFS_W = 12,
    parameter int LUT_AW = 10,
    parameter int DW     = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 fsel_i,
    input  logic                 sleep_i,
    input  logic                 ld_en_i,
    input  logic [2:0]           ld_dst_i,
    input  logic [ACC_W-1:0]     ld_data_i,
    output logic signed [DW-1:0] sample_o
);
    logic                 ctrl_sleep;
    logic [ACC_W-1:0]     tune_a;
    logic [ACC_W-1:0]     tune_b;
    logic [POFS_W-1:0]    pofs;
    logic signed [DW-1:0] iq_i;
    logic signed [DW-1:0] iq_q;
    logic                 awake;
    logic [ACC_W-1:0]     acc_q;
    logic                 fsel_q;
    logic signed [DW-1:0] sin_q;
    logic signed [DW-1:0] cos_q;

    assign awake = !(sleep_i || ctrl_sleep);

    dds_nco_regs #(.ACC_W(ACC_W), .POFS_W(POFS_W), .DW(DW)) u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .ld_en_i      (ld_en_i),
        .ld_dst_i     (load_dst_e'(ld_dst_i)),
        .ld_data_i    (ld_data_i),
        .ctrl_sleep_o (ctrl_sleep),
        .tune_a_o     (tune_a),
        .tune_b_o     (tune_b),
        .pofs_o       (pofs),
        .iq_i_o       (iq_i),
        .iq_q_o       (iq_q)
    );

    dds_nco_phase #(.ACC_W(ACC_W)) u_phase (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .awake_i  (awake),
        .fsel_i   (fsel_i),
        .tune_a_i (tune_a),
        .tune_b_i (tune_b),
        .acc_o    (acc_q),
        .fsel_q_o (fsel_q)
    );

    dds_nco_trig #(.POFS_W(POFS_W), .LUT_AW(LUT_AW), .DW(DW)) u_trig (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .awake_i     (awake),
        .phase_top_i (acc_q[ACC_W-1 -: POFS_W]),
        .pofs_i      (pofs),
        .sin_o       (sin_q),
        .cos_o       (cos_q)
    );

    dds_nco_mix #(.DW(DW)) u_mix (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .awake_i  (awake),
        .sin_i    (sin_q),
        .cos_i    (cos_q),
        .iq_i_i   (iq_i),
        .iq_q_i   (iq_q),
        .sample_o (sample_o)
    );
endmodule

// File: rtl/dds_nco_chk.sv
module dds_nco_chk #(
    parameter int ACC_W = 32,
    parameter int DW    = 10
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 fsel_i,
    input logic                 sleep_i,
    input logic                 awake,
    input logic                 fsel_q,
    input logic [ACC_W-1:0]     acc_q,
    input logic [ACC_W-1:0]     tune_a,
    input logic [ACC_W-1:0]     tune_b,
    input logic                 ld_en_i,
    input logic [2:0]           ld_dst_i,
    input logic [ACC_W-1:0]     ld_data_i,
    input logic signed [DW-1:0] sample_o
);
    // R1
    acc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        awake |=> acc_q == $past(acc_q) + ($past(fsel_q) ? $past(tune_b) : $past(tune_a)));

    // R2
    fsel_reg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> fsel_q == $past(fsel_i));

    // R7
    sleep_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sleep_i |=> sample_o == '0);

    // R8
    sleep_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !awake |=> $stable(acc_q));

    // R10
    load_tune_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ld_en_i && ld_dst_i == 3'd1) |=> tune_a == $past(ld_data_i));
endmodule

bind dds_dual_nco dds_nco_chk #(.ACC_W(ACC_W), .DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .fsel_i    (fsel_i),
    .sleep_i   (sleep_i),
    .awake     (awake),
    .fsel_q    (fsel_q),
    .acc_q     (acc_q),
    .tune_a    (tune_a),
    .tune_b    (tune_b),
    .ld_en_i   (ld_en_i),
    .ld_dst_i  (ld_dst_i),
    .ld_data_i (ld_data_i),
    .sample_o  (sample_o)
);

// File: tb/dds_dual_nco_bench.sv
`timescale 1ns/1ps
module dds_dual_nco_bench;
    localparam int ACC_W = 32;
    localparam int DW    = 10;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 fsel = 1'b0;
    logic                 slp = 1'b0;
    logic                 ld_en = 1'b0;
    logic [2:0]           ld_dst = 3'd0;
    logic [ACC_W-1:0]     ld_data = '0;
    logic signed [DW-1:0] sample;

    always #2 clk = ~clk;

    dds_dual_nco u_dds_dual_nco (
        .clk_i     (clk),
        .rst_i     (rst),
        .fsel_i    (fsel),
        .sleep_i   (slp),
        .ld_en_i   (ld_en),
        .ld_dst_i  (ld_dst),
        .ld_data_i (ld_data),
        .sample_o  (sample)
    );

    typedef struct { int exp; string tag; } item_t;
    item_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_fa = '0, m_fb = '0, m_acc = '0;
    int m_ph = 0, m_i = 0, m_q = 0, m_sin = 0, m_cos = 0;
    bit m_slp = 0, m_fsel = 0;

    function automatic int ref_tab(int p);
        real v;
        v = 511.0 * $sin(2.0 * 3.14159265358979 * (p + 0.5) / 1024.0);
        return $rtoi($floor(v + 0.5));
    endfunction

    function automatic int ref_mix(int s, int c, int iw, int qw);
        int r;
        r = (iw * c + qw * s + 256) >>> 9;
        if (r > 511) r = 511;
        if (r < -512) r = -512;
        return r;
    endfunction

    task automatic step(input bit f, input bit sl, input bit le, input int dst,
                        input logic [31:0] d, input bit r, input string tag);
        bit aw;
        int nsmp, p;
        @(negedge clk);
        fsel = f; slp = sl; ld_en = le; ld_dst = dst[2:0]; ld_data = d; rst = r;
        aw = !(sl || m_slp);
        if (r) begin
            m_fa = '0; m_fb = '0; m_acc = '0; m_ph = 0; m_i = 0; m_q = 0;
            m_sin = 0; m_cos = 0; m_slp = 0; m_fsel = 0; nsmp = 0;
        end else begin
            nsmp = aw ? ref_mix(m_sin, m_cos, m_i, m_q) : 0;
            if (aw) begin
                p = ((int'(m_acc >> 20) + m_ph) & 4095) >> 2;
                m_sin = ref_tab(p);
                m_cos = ref_tab((p + 256) & 1023);
                m_acc = m_acc + (m_fsel ? m_fb : m_fa);
            end
            m_fsel = f;
            if (le) begin
                case (dst)
                    0: m_slp = d[0];
                    1: m_fa = d;
                    2: m_fb = d;
                    3: m_ph = int'(d[11:0]);
                    4: begin
                        m_i = $signed(d[25:16]);
                        m_q = $signed(d[9:0]);
                    end
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        sb.push_back('{nsmp, tag});
    endtask

    task automatic idle(input int n, input bit f, input bit sl, input string tag);
        for (int k = 0; k < n; k++) step(f, sl, 0, 0, '0, 0, tag);
    endtask

    task automatic load(input int dst, input logic [31:0] d, input string tag);
        step(0, 0, 1, dst, d, 0, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (int'(sample) != it.exp) begin
                    n_fail++;
                    $display("FAIL %s: sample actual=%0d expected=%0d", it.tag, int'(sample), it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, '0, 1, "R9 reset state");
        load(4, 32'h01FF_0000, "R10 iq load");
        load(1, 32'h0123_4567, "R10 tune A");
        load(2, 32'h4000_0000, "R10 tune B");
        idle(24, 0, 0, "R1 tune A run");
        for (int k = 0; k < 16; k++) step(k[0], 0, 0, 0, '0, 0, "R2 per-cycle select");
        load(3, 32'h0000_0400, "R3 quarter offset");
        idle(8, 0, 0, "R3 quarter offset");
        load(3, 32'h0000_0FFF, "R3 offset wrap");
        idle(4, 0, 0, "R3 offset wrap");
        load(3, 32'h0, "R3 offset clear");
        load(1, 32'hC000_0000, "R1 wrap word");
        idle(8, 0, 0, "R1 accumulator wrap");
        load(1, 32'h0040_0000, "R4 index sweep");
        idle(40, 0, 0, "R4 table values");
        load(4, 32'h0000_01FF, "R5 quadrature only");
        idle(10, 0, 0, "R5 quadrature only");
        load(4, 32'h0300_00C8, "R5 mixed weights");
        idle(10, 0, 0, "R5 mixed weights");
        load(4, 32'h0200_0200, "R6 negative full scale");
        load(1, 32'h2000_0000, "R6 octant steps");
        idle(12, 0, 0, "R6 saturation");
        load(4, 32'h01FF_0000, "R7 restore iq");
        idle(6, 0, 1, "R7 sleep pin");
        idle(4, 0, 0, "R7 wake");
        load(0, 32'h1, "R8 sleep bit set");
        idle(6, 0, 0, "R8 sleep bit");
        load(0, 32'h0, "R8 sleep bit clear");
        idle(4, 0, 0, "R8 wake");
        load(5, 32'hDEAD_BEEF, "R10 code 5 ignored");
        load(7, 32'hDEAD_BEEF, "R10 code 7 ignored");
        idle(6, 0, 0, "R10 after ignored codes");
        load(1, 32'h0, "R11 freeze accumulator");
        idle(3, 0, 0, "R11 steady");
        load(3, 32'h0000_0800, "R11 offset step");
        idle(3, 0, 0, "R11 latency");
        step(0, 0, 0, 0, '0, 1, "R9 mid-run reset");
        step(0, 0, 0, 0, '0, 1, "R9 mid-run reset");
        idle(3, 0, 0, "R9 after reset");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule